// File: doc/BRIEF.md
# HDLC Interrupt Status and Mask Unit

This block gathers single-cycle event strobes from an HDLC receive engine, a transmit engine and the FIFO control around them. Each strobe sets a sticky flag in an 8-bit status word. A second 8-bit word, the mask, uses the same bit positions and decides which flags may drive the single active-high interrupt line toward the host.

The host sees two plain register strobes. A read of the status address returns the flags one cycle later and clears all of them together. A write to the mask address loads the enables. Apart from a read, flags are cleared by their own sources: the receiver reset command clears the receive overflow flag. The transmitter reset command clears the underrun and all-sent flags and raises the transmit-pool-ready flag. An event that lands in the same cycle as any clearing source still leaves its flag set, so no event is lost.

Top module: `hdlc_irq_unit`

## Requirements
- R1: After hardware reset every flag and every mask bit is 0, `irqOut` is low and `regRdata` is 0.
- R2: `irqOut` is high exactly when some flag is set and its mask bit is 1; a 0 mask bit keeps that flag off the line while the flag itself is kept.
- R3: A read strobe at address 0x20 puts the flags on `regRdata` in the cycle after the strobe and clears all flags at once. The bit layout is 7 message-end, 6 receive-pool-full, 5 receive-overflow, 4 transmit-pool-ready, 3 underrun, 2 all-sent, and bits 1..0 read as 0.
- R4: The receive-overflow flag (bit 5) sets only when `rxHiddenFull` and `rxFrameStart` are high in the same cycle; either one alone has no effect.
- R5: `cmdRxReset` clears only the receive-overflow flag and leaves bits 7, 6, 4, 3 and 2 as they were.
- R6: `cmdTxReset` clears the underrun (bit 3) and all-sent (bit 2) flags and sets the transmit-pool-ready flag (bit 4); it leaves bits 7, 6 and 5 as they were.
- R7: Each event input sets its own flag, which stays set until a clearing source acts on it.
- R8: When a flag's set event and one of its clearing sources (read, receiver reset) fall in the same cycle, the flag ends up set.
- R9: A write strobe at address 0x2C loads the mask from `regWdata` bits 7..2 in the status layout; writes to other addresses change nothing. Reads at any other address return 0 and clear no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| evRxMsgEnd | input | 1 | Receive message-end event (bit 7) |
| evRxPoolFull | input | 1 | Receive pool full event (bit 6) |
| rxHiddenFull | input | 1 | Host-inaccessible receive FIFO part is full |
| rxFrameStart | input | 1 | Start of a new receive frame detected |
| evTxPoolReady | input | 1 | Transmit command finished, pool ready (bit 4) |
| evTxUnderrun | input | 1 | Transmit engine asked an empty FIFO for data (bit 3) |
| evTxAllSent | input | 1 | Last bit of a frame left the line (bit 2) |
| cmdRxReset | input | 1 | Receiver reset command strobe |
| cmdTxReset | input | 1 | Transmitter reset command strobe |
| regAddr | input | 8 | Register address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, valid the cycle after `regRd` |
| irqOut | output | 1 | Active-high interrupt request |

## Verification
The bench drives events at the same time as a status read and as a receiver reset. A design in which the clear beats the set would drop those events, so a second read finds them missing. It raises the two overflow conditions in separate cycles. A design that ORs them instead of ANDing them would report an overflow. It issues a transmitter reset over set underrun and all-sent flags. A design that left those flags set, or that failed to raise pool-ready, returns the wrong word. It also writes near the mask address and reads near the status address, so that a loose address decode shows up as a changed interrupt line or as lost flags.

// File: rtl/hdlc_irq_pkg.sv
package hdlc_irq_pkg;
  localparam int FLAG_CNT = 6;
  localparam int FLAG_LSB = 2;

  // flag index, LSB first; bit position in the register is FLAG_LSB + index
  localparam int IDX_ALLS = 0;
  localparam int IDX_UNDR = 1;
  localparam int IDX_TXPR = 2;
  localparam int IDX_ROVF = 3;
  localparam int IDX_RPFL = 4;
  localparam int IDX_RMSG = 5;

  // per-flag behaviour toward the reset commands
  localparam logic [FLAG_CNT-1:0] CLR_BY_RX = 6'b001000;
  localparam logic [FLAG_CNT-1:0] CLR_BY_TX = 6'b000011;
  localparam logic [FLAG_CNT-1:0] SET_BY_TX = 6'b000100;

  typedef struct packed {
    logic isrRead;
    logic maskWrite;
    logic rxReset;
    logic txReset;
  } irqStrobes_t;
endpackage

// File: rtl/hdlc_irq_flag.sv
module hdlc_irq_flag #(
  parameter bit CLR_RX = 1'b0,
  parameter bit CLR_TX = 1'b0,
  parameter bit SET_TX = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic setPulse,
  input  logic rdClear,
  input  logic rxReset,
  input  logic txReset,
  output logic flagQ
);
  logic setHit;
  logic clrHit;

  assign setHit = setPulse | (SET_TX & txReset);
  assign clrHit = rdClear | (CLR_RX & rxReset) | (CLR_TX & txReset);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       flagQ <= 1'b0;
    else if (setHit) flagQ <= 1'b1;
    else if (clrHit) flagQ <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    setPulse |=> flagQ); // R8

  generate
    if (SET_TX) begin : gTxSet
      AST_TXRST_RAISES: assert property (@(posedge clk) disable iff (!rstN)
        txReset |=> flagQ); // R6
    end
  endgenerate
endmodule

// File: rtl/hdlc_irq_ctrl.sv
module hdlc_irq_ctrl
  import hdlc_irq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h20,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h2C
) (
  input  logic              evRxMsgEnd,
  input  logic              evRxPoolFull,
  input  logic              rxHiddenFull,
  input  logic              rxFrameStart,
  input  logic              evTxPoolReady,
  input  logic              evTxUnderrun,
  input  logic              evTxAllSent,
  input  logic              cmdRxReset,
  input  logic              cmdTxReset,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  output irqStrobes_t       strb,
  output logic [FLAG_CNT-1:0] setVec
);
  always_comb begin
    strb.isrRead   = regRd & (regAddr == STAT_ADDR);
    strb.maskWrite = regWr & (regAddr == MASK_ADDR);
    strb.rxReset   = cmdRxReset;
    strb.txReset   = cmdTxReset;
  end

  always_comb begin
    setVec           = '0;
    setVec[IDX_RMSG] = evRxMsgEnd;
    setVec[IDX_RPFL] = evRxPoolFull;
    setVec[IDX_ROVF] = rxHiddenFull & rxFrameStart;
    setVec[IDX_TXPR] = evTxPoolReady;
    setVec[IDX_UNDR] = evTxUnderrun;
    setVec[IDX_ALLS] = evTxAllSent;
  end
endmodule

// File: rtl/hdlc_irq_dp.sv
module hdlc_irq_dp
  import hdlc_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  irqStrobes_t         strb,
  input  logic [FLAG_CNT-1:0] setVec,
  input  logic                rxHiddenFull,
  input  logic                rxFrameStart,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic                irqOut
);
  logic [FLAG_CNT-1:0] flagQ;
  logic [FLAG_CNT-1:0] maskQ;
  logic [DATA_W-1:0]   statWord;

  generate
    for (genvar i = 0; i < FLAG_CNT; i++) begin : gFlag
      hdlc_irq_flag #(
        .CLR_RX(CLR_BY_RX[i]),
        .CLR_TX(CLR_BY_TX[i]),
        .SET_TX(SET_BY_TX[i])
      ) uFlag (
        .clk(clk),
        .rstN(rstN),
        .setPulse(setVec[i]),
        .rdClear(strb.isrRead),
        .rxReset(strb.rxReset),
        .txReset(strb.txReset),
        .flagQ(flagQ[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              maskQ <= '0;
    else if (strb.maskWrite) maskQ <= regWdata[FLAG_LSB +: FLAG_CNT];
  end

  always_comb begin
    statWord = '0;
    statWord[FLAG_LSB +: FLAG_CNT] = flagQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdata <= '0;
    else       regRdata <= strb.isrRead ? statWord : '0;
  end

  assign irqOut = |(flagQ & maskQ);

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskQ != '0)); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[FLAG_LSB-1:0] == '0); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.isrRead && setVec == '0 && !strb.txReset) |=> flagQ == '0); // R3
  AST_OVF_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ[IDX_ROVF]) |-> $past(rxHiddenFull && rxFrameStart)); // R4
  AST_RXRST_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxReset && !setVec[IDX_ROVF]) |=> !flagQ[IDX_ROVF]); // R5
endmodule

// File: rtl/hdlc_irq_unit.sv
module hdlc_irq_unit
  import hdlc_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evRxMsgEnd,
  input  logic              evRxPoolFull,
  input  logic              rxHiddenFull,
  input  logic              rxFrameStart,
  input  logic              evTxPoolReady,
  input  logic              evTxUnderrun,
  input  logic              evTxAllSent,
  input  logic              cmdRxReset,
  input  logic              cmdTxReset,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);
  irqStrobes_t         strb;
  logic [FLAG_CNT-1:0] setVec;

  hdlc_irq_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .evRxMsgEnd(evRxMsgEnd),
    .evRxPoolFull(evRxPoolFull),
    .rxHiddenFull(rxHiddenFull),
    .rxFrameStart(rxFrameStart),
    .evTxPoolReady(evTxPoolReady),
    .evTxUnderrun(evTxUnderrun),
    .evTxAllSent(evTxAllSent),
    .cmdRxReset(cmdRxReset),
    .cmdTxReset(cmdTxReset),
    .regAddr(regAddr),
    .regWr(regWr),
    .regRd(regRd),
    .strb(strb),
    .setVec(setVec)
  );

  hdlc_irq_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .setVec(setVec),
    .rxHiddenFull(rxHiddenFull),
    .rxFrameStart(rxFrameStart),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .irqOut(irqOut)
  );
endmodule

// File: tb/sim_hdlc_irq_unit.sv
`timescale 1ns/1ps
module sim_hdlc_irq_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evRxMsgEnd = 0, evRxPoolFull = 0, rxHiddenFull = 0, rxFrameStart = 0;
  logic evTxPoolReady = 0, evTxUnderrun = 0, evTxAllSent = 0;
  logic cmdRxReset = 0, cmdTxReset = 0;
  logic [7:0] regAddr = 8'h00;
  logic regWr = 0, regRd = 0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       rdFlag = 0;

  localparam logic [7:0] STAT = 8'h20;
  localparam logic [7:0] MASK = 8'h2C;

  always #2.5 clk = ~clk;

  hdlc_irq_unit u0 (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clearIns();
    evRxMsgEnd = 0; evRxPoolFull = 0; rxHiddenFull = 0; rxFrameStart = 0;
    evTxPoolReady = 0; evTxUnderrun = 0; evTxAllSent = 0;
    cmdRxReset = 0; cmdTxReset = 0; regWr = 0; regRd = 0;
  endtask

  // driver: read of the status word, expectation goes to the scoreboard
  task automatic pushRead(logic [7:0] exp, string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    regAddr = STAT;
    regRd = 1;
  endtask

  task automatic readStat(logic [7:0] exp, string tag);
    pushRead(exp, tag);
    tick();
    clearIns();
    tick();
  endtask

  task automatic writeReg(logic [7:0] addr, logic [7:0] val);
    regAddr = addr; regWdata = val; regWr = 1;
    tick();
    clearIns();
  endtask

  always @(posedge clk) rdFlag <= regRd && (regAddr == STAT);

  // monitor: compare status data in the cycle after each status read
  always @(negedge clk) begin
    if (rdFlag) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R3: unexpected read data actual=%02h expected=none", regRdata);
      end else begin
        check(tagQ.pop_front(), regRdata, expQ.pop_front());
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish();
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    check("R1 irq after reset", {7'd0, irqOut}, 8'h00);
    check("R1 rdata after reset", regRdata, 8'h00);
    readStat(8'h00, "R1 flags after reset");

    // masked flag keeps irq low; read returns and clears
    evRxMsgEnd = 1; tick(); clearIns();
    check("R2 masked irq low", {7'd0, irqOut}, 8'h00);
    readStat(8'h80, "R3 R7 message-end read");
    readStat(8'h00, "R3 cleared after read");

    // mask enable, wrong-address write ignored
    writeReg(MASK, 8'h80);
    evRxMsgEnd = 1; tick(); clearIns();
    check("R2 irq with mask", {7'd0, irqOut}, 8'h01);
    writeReg(8'h2D, 8'h00);
    check("R9 stray write ignored", {7'd0, irqOut}, 8'h01);
    regAddr = 8'h21; regRd = 1; tick(); clearIns();
    check("R9 other read returns 0", regRdata, 8'h00);
    check("R9 other read keeps flag", {7'd0, irqOut}, 8'h01);
    readStat(8'h80, "R3 masked read");
    check("R3 irq low after read", {7'd0, irqOut}, 8'h00);

    // overflow needs both conditions in one cycle
    rxHiddenFull = 1; tick(); clearIns();
    rxFrameStart = 1; tick(); clearIns();
    readStat(8'h00, "R4 single condition ignored");
    rxHiddenFull = 1; rxFrameStart = 1; tick(); clearIns();
    readStat(8'h20, "R4 overflow set");

    // receiver reset clears only overflow
    evRxPoolFull = 1; rxHiddenFull = 1; rxFrameStart = 1; evTxUnderrun = 1; evTxPoolReady = 1;
    tick(); clearIns();
    cmdRxReset = 1; tick(); clearIns();
    readStat(8'h58, "R5 rx reset");

    // transmitter reset clears underrun/all-sent, raises pool-ready
    evTxUnderrun = 1; evTxAllSent = 1; evRxMsgEnd = 1; rxHiddenFull = 1; rxFrameStart = 1;
    tick(); clearIns();
    cmdTxReset = 1; tick(); clearIns();
    readStat(8'hB0, "R6 tx reset");

    // set wins over read and over receiver reset
    evRxMsgEnd = 1; tick(); clearIns();
    pushRead(8'h80, "R8 read with event");
    evTxAllSent = 1; tick(); clearIns(); tick();
    readStat(8'h04, "R8 event kept after read");
    rxHiddenFull = 1; rxFrameStart = 1; cmdRxReset = 1; tick(); clearIns();
    readStat(8'h20, "R8 overflow beats rx reset");

    // all flags, full mask then mask cleared
    writeReg(MASK, 8'hFF);
    evTxAllSent = 1; tick(); clearIns();
    check("R2 all-sent irq", {7'd0, irqOut}, 8'h01);
    evRxMsgEnd = 1; evRxPoolFull = 1; rxHiddenFull = 1; rxFrameStart = 1;
    evTxPoolReady = 1; evTxUnderrun = 1; tick(); clearIns();
    writeReg(MASK, 8'h00);
    check("R2 zero mask blocks", {7'd0, irqOut}, 8'h00);
    readStat(8'hFC, "R7 all flags held");

    tick();
    check("R3 scoreboard drained", 8'(expQ.size()), 8'h00);
    finish();
  end
endmodule